// File: doc/BRIEF.md
# Interleaved Feature-Map Bank Scheduler

This controller decides which computing unit owns each feature-map buffer group in a pipelined CNN accelerator. The pipeline has a configurable number of units; the default is three: convolution stage A, convolution stage B and a fully-connected stage. There are `2*N_UNITS+2` groups, which gives eight by default. Each frame in flight is tied to one parity. Even frames use only even-numbered groups and odd frames use only odd-numbered groups. The external loader therefore writes successive frames into group 0 and group 1 in turn.

Unit k sees a window of four groups that starts at group 2k. Neighbouring units share two of those groups. For a frame of parity q, unit k reads group `2k+q` and writes group `2k+2+q`. The output group of one stage is the input group of the next, so data moves between stages with no copy.

A loader pulses `frame_start_i` once a frame sits in the group named by `load_grp_o`. Each unit pulses its bit of `unit_done_i` when it has finished the frame it holds. The block reports, for every group, whether it is held, which unit holds it and the parity of the frame it carries.

Top module: `ibs_bank_sched`

## Requirements
- R1: After reset the current parity is even, no group is held, `load_grp_o` is 0 and `load_ready_o` is 1.
- R2: An accepted `frame_start_i` (pulse while `load_ready_o` is 1) toggles the parity. `load_grp_o` then names group 0 for even and group 1 for odd, one cycle after the accepting edge.
- R3: `load_ready_o` is 0 while the group `load_grp_o` still holds a frame not yet taken by unit 0, or while unit 0 holds that group. A `frame_start_i` pulse while it is 0 is ignored and leaves `load_grp_o` unchanged.
- R4: While unit k holds a frame of parity q, groups `2k+q` and `2k+2+q` report owner code k+1. Owner code 0 means the group is free. The code sits at bits `[2g+1:2g]` of `grp_owner_o` for group g, and `grp_sel_o[g]` is 1 exactly when the code is nonzero.
- R5: A held group's `grp_par_o` bit equals the parity of the frame using it, which is always the group index's least significant bit. A free group reports 0.
- R6: No group is ever held by two units in the same cycle.
- R7: A unit whose output group is held by the next unit, or which still holds a frame that unit has not taken, does not start. It starts on the edge after the next unit's accepted done.
- R8: A done pulse frees both groups of the unit on the next edge. A done pulse to a unit that holds nothing has no effect.
- R9: Each unit takes frames in arrival order, so its successive frames alternate in parity, starting even.
- R10: A unit begins a frame on the first edge at which it is idle, its input frame is present and its output group is free. Ownership is visible after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Loader has filled `load_grp_o` with a new frame |
| unit_done_i | input | N_UNITS | Per-unit pulse: current frame finished |
| load_grp_o | output | $clog2(NG) | Group the loader must fill next |
| load_ready_o | output | 1 | Loader group is free; a start will be accepted |
| grp_sel_o | output | NG | Group is held by a unit |
| grp_owner_o | output | NG*2 | Per-group owner code, 0 free, k+1 for unit k |
| grp_par_o | output | NG | Parity of the frame in a held group |

## Verification
The assertions assume that the loader pulses `frame_start_i` only after it has actually filled the named group. They also assume that a done pulse from a unit reports completion of the frame that unit currently holds. The bench drives frame starts and done pulses freely, including starts while `load_ready_o` is low and done pulses to idle units. It relies on the block to discard them, which the reference model also does. The directed part steers the pipeline into a stall with both parities in flight. The random part then mixes starts and done pulses at high density so that blocked and overlapping windows occur often.

// File: rtl/ibs_pkg.sv
package ibs_pkg;
  localparam int unsigned WIN_STEP = 2;
  function automatic int unsigned grp_count(input int unsigned n_units);
    return WIN_STEP * n_units + 2;
  endfunction
endpackage

// File: rtl/ibs_unit_slot.sv
module ibs_unit_slot #(
  parameter int unsigned NG  = 8,
  parameter int unsigned IDX = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic          set_par_i,
  input  logic          done_i,
  input  logic [1:0]    dn_free_i,
  output logic          act_o,
  output logic          par_o,
  output logic [1:0]    rdy_o,
  output logic          rel_o,
  output logic [NG-1:0] claim_o
);
  localparam int unsigned RD = ibs_pkg::WIN_STEP * IDX;
  localparam int unsigned WR = RD + 2;

  logic act_q, par_q, nxt_q, go;
  logic [1:0] rdy_q, rdy_d;

  assign go    = !act_q && rdy_q[nxt_q] && dn_free_i[nxt_q];
  assign rel_o = act_q && done_i;
  assign act_o = act_q;
  assign par_o = par_q;
  assign rdy_o = rdy_q;

  always_comb begin
    rdy_d = rdy_q;
    if (go)    rdy_d[nxt_q]     = 1'b0;
    if (set_i) rdy_d[set_par_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      par_q <= 1'b0;
      nxt_q <= 1'b0;
      rdy_q <= '0;
    end else begin
      rdy_q <= rdy_d;
      if (go) begin
        act_q <= 1'b1;
        par_q <= nxt_q;
        nxt_q <= ~nxt_q;
      end else if (rel_o) begin
        act_q <= 1'b0;
      end
    end
  end

  always_comb begin
    claim_o = '0;
    if (act_q) begin
      claim_o[RD + 32'(par_q)] = 1'b1;
      claim_o[WR + 32'(par_q)] = 1'b1;
    end
  end
endmodule

// File: rtl/ibs_grp_map.sv
module ibs_grp_map #(
  parameter int unsigned NU = 3,
  parameter int unsigned NG = 8,
  parameter int unsigned OW = 2
) (
  input  logic [NU-1:0][NG-1:0] claim_i,
  input  logic [NU-1:0]         upar_i,
  output logic [NG-1:0]         sel_o,
  output logic [NG*OW-1:0]      owner_o,
  output logic [NG-1:0]         par_o
);
  always_comb begin
    sel_o   = '0;
    owner_o = '0;
    par_o   = '0;
    for (int g = 0; g < int'(NG); g++) begin
      for (int u = int'(NU) - 1; u >= 0; u--) begin
        if (claim_i[u][g]) begin
          sel_o[g]           = 1'b1;
          owner_o[g*OW +: OW] = OW'(u + 1);
          par_o[g]           = upar_i[u];
        end
      end
    end
  end
endmodule

// File: rtl/ibs_bank_sched.sv
module ibs_bank_sched #(
  parameter int unsigned N_UNITS = 3,
  localparam int unsigned NG = ibs_pkg::grp_count(N_UNITS),
  localparam int unsigned GW = $clog2(NG),
  localparam int unsigned OW = $clog2(N_UNITS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_start_i,
  input  logic [N_UNITS-1:0] unit_done_i,
  output logic [GW-1:0]      load_grp_o,
  output logic               load_ready_o,
  output logic [NG-1:0]      grp_sel_o,
  output logic [NG*OW-1:0]   grp_owner_o,
  output logic [NG-1:0]      grp_par_o
);
  logic                        par_q, start_acc;
  logic [N_UNITS-1:0]          act_w, upar_w, rel_w;
  logic [N_UNITS-1:0][1:0]     rdy_w;
  logic [N_UNITS-1:0][NG-1:0]  claim_w;

  assign load_ready_o = !rdy_w[0][par_q] && !(act_w[0] && upar_w[0] == par_q);
  assign start_acc    = frame_start_i && load_ready_o;
  assign load_grp_o   = {{(GW-1){1'b0}}, par_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        par_q <= 1'b0;
    else if (start_acc) par_q <= ~par_q;
  end

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    logic       set_w, set_par_w;
    logic [1:0] free_w;
    if (u == 0) begin : g_head
      assign set_w     = start_acc;
      assign set_par_w = par_q;
    end else begin : g_mid
      assign set_w     = rel_w[u-1];
      assign set_par_w = upar_w[u-1];
    end
    if (u == N_UNITS - 1) begin : g_tail
      assign free_w = 2'b11;
    end else begin : g_link
      for (genvar q = 0; q < 2; q++) begin : g_q
        assign free_w[q] = !(act_w[u+1] && upar_w[u+1] == 1'(q)) && !rdy_w[u+1][q];
      end
    end
    ibs_unit_slot #(.NG(NG), .IDX(u)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (set_w),
      .set_par_i (set_par_w),
      .done_i    (unit_done_i[u]),
      .dn_free_i (free_w),
      .act_o     (act_w[u]),
      .par_o     (upar_w[u]),
      .rdy_o     (rdy_w[u]),
      .rel_o     (rel_w[u]),
      .claim_o   (claim_w[u])
    );
  end

  ibs_grp_map #(.NU(N_UNITS), .NG(NG), .OW(OW)) u_map (
    .claim_i (claim_w),
    .upar_i  (upar_w),
    .sel_o   (grp_sel_o),
    .owner_o (grp_owner_o),
    .par_o   (grp_par_o)
  );
endmodule

// File: rtl/ibs_sched_chk.sv
module ibs_sched_chk #(
  parameter int unsigned N_UNITS = 3,
  parameter int unsigned NG = 8,
  parameter int unsigned GW = 3
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       frame_start_i,
  input logic [N_UNITS-1:0]         unit_done_i,
  input logic [GW-1:0]              load_grp_o,
  input logic                       load_ready_o,
  input logic [NG-1:0]              grp_sel_o,
  input logic [NG-1:0]              grp_par_o,
  input logic [N_UNITS-1:0]         act_w,
  input logic [N_UNITS-1:0][NG-1:0] claim_w
);
  p_load_toggle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && load_ready_o |=> load_grp_o != $past(load_grp_o));

  p_load_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_start_i && load_ready_o) |=> $stable(load_grp_o));

  for (genvar g = 0; g < NG; g++) begin : g_grp
    p_par_idx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grp_sel_o[g] |-> grp_par_o[g] == 1'(g % 2));
  end

  for (genvar a = 0; a < N_UNITS; a++) begin : g_a
    p_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_w[a] && unit_done_i[a] |=> !act_w[a]);
    for (genvar b = a + 1; b < N_UNITS; b++) begin : g_b
      p_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (claim_w[a] & claim_w[b]) == '0);
    end
  end
endmodule

bind ibs_bank_sched ibs_sched_chk #(.N_UNITS(N_UNITS), .NG(NG), .GW(GW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_start_i (frame_start_i),
  .unit_done_i   (unit_done_i),
  .load_grp_o    (load_grp_o),
  .load_ready_o  (load_ready_o),
  .grp_sel_o     (grp_sel_o),
  .grp_par_o     (grp_par_o),
  .act_w         (act_w),
  .claim_w       (claim_w)
);

// File: tb/tb_ibs_bank_sched.sv
`timescale 1ns/1ps
module tb_ibs_bank_sched;
  localparam int NU = 3;
  localparam int NG = 8;
  localparam int GW = 3;
  localparam int OW = 2;

  logic clk = 1'b0, rst_ni = 1'b0, fs = 1'b0;
  logic [NU-1:0] dn = '0;
  logic [GW-1:0] load_grp;
  logic load_ready;
  logic [NG-1:0] sel, gpar;
  logic [NG*OW-1:0] owner;

  ibs_bank_sched #(.N_UNITS(NU)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .frame_start_i(fs), .unit_done_i(dn),
    .load_grp_o(load_grp), .load_ready_o(load_ready),
    .grp_sel_o(sel), .grp_owner_o(owner), .grp_par_o(gpar)
  );

  always #2 clk = ~clk;

  int errs = 0, chks = 0;
  bit fin = 0;

  // behavioural reference
  int m_act[NU], m_par[NU], m_nxt[NU], m_rdy[NU][2], m_p;

  function automatic int m_free(int u, int q);
    if (u == NU - 1) return 1;
    return (!(m_act[u+1] != 0 && m_par[u+1] == q) && m_rdy[u+1][q] == 0) ? 1 : 0;
  endfunction

  function automatic int m_lr();
    return (m_rdy[0][m_p] == 0 && !(m_act[0] != 0 && m_par[0] == m_p)) ? 1 : 0;
  endfunction

  function automatic int m_owner(int g);
    for (int u = 0; u < NU; u++)
      if (m_act[u] != 0 && (g == 2*u + m_par[u] || g == 2*u + 2 + m_par[u])) return u + 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_p = 0;
      for (int u = 0; u < NU; u++) begin
        m_act[u] = 0; m_par[u] = 0; m_nxt[u] = 0; m_rdy[u][0] = 0; m_rdy[u][1] = 0;
      end
    end else begin
      int go[NU], rel[NU], relp[NU], acc;
      acc = (fs && m_lr() != 0) ? 1 : 0;
      for (int u = 0; u < NU; u++) begin
        go[u]   = (m_act[u] == 0 && m_rdy[u][m_nxt[u]] != 0 && m_free(u, m_nxt[u]) != 0) ? 1 : 0;
        rel[u]  = (m_act[u] != 0 && dn[u]) ? 1 : 0;
        relp[u] = m_par[u];
      end
      for (int u = 0; u < NU; u++) begin
        if (go[u] != 0) begin
          m_rdy[u][m_nxt[u]] = 0;
          m_act[u] = 1; m_par[u] = m_nxt[u]; m_nxt[u] = 1 - m_nxt[u];
        end else if (rel[u] != 0) m_act[u] = 0;
      end
      if (acc != 0) begin m_rdy[0][m_p] = 1; m_p = 1 - m_p; end
      for (int u = 1; u < NU; u++) if (rel[u-1] != 0) m_rdy[u][relp[u-1]] = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int own(int g);
    return int'(owner[g*OW +: OW]);
  endfunction

  always @(negedge clk) begin
    if (rst_ni && !fin) begin
      for (int g = 0; g < NG; g++) begin
        chk(own(g) == m_owner(g), "R4 owner", own(g), m_owner(g));
        chk(sel[g] == (m_owner(g) != 0), "R6 sel", int'(sel[g]), int'(m_owner(g) != 0));
        chk(int'(gpar[g]) == ((m_owner(g) != 0) ? g % 2 : 0), "R5 par", int'(gpar[g]),
            (m_owner(g) != 0) ? g % 2 : 0);
      end
      chk(int'(load_grp) == m_p, "R2 load_grp", int'(load_grp), m_p);
      chk(int'(load_ready) == m_lr(), "R3 load_ready", int'(load_ready), m_lr());
    end
  end

  task automatic tick(input bit s, input logic [NU-1:0] d);
    fs = s; dn = d;
    @(negedge clk);
    fs = 1'b0; dn = '0;
  endtask

  task automatic finish_run();
    fin = 1;
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  endtask

  initial begin
    #800000;
    if (!fin) begin
      chks++; errs++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(load_grp == 0 && load_ready && sel == 0, "R1 reset", int'(sel), 0);
    tick(0, 3'b111);
    chk(sel == 0 && load_ready, "R8 idle done ignored", int'(sel), 0);
    tick(1, 0);
    chk(load_grp == 1, "R2 toggle", int'(load_grp), 1);
    tick(0, 0);
    chk(own(0) == 1 && own(2) == 1, "R10 start latency", own(2), 1);
    tick(1, 0);
    tick(0, 3'b001);
    chk(sel == 0, "R8 release", int'(sel), 0);
    tick(0, 0);
    chk(own(1) == 1 && own(3) == 1 && own(2) == 2 && own(4) == 2, "R9 alternation", own(1), 1);
    tick(1, 0);
    tick(0, 3'b001);
    tick(0, 0);
    chk(own(0) == 0 && own(2) == 2, "R7 upstream waits", own(0), 0);
    tick(0, 3'b010);
    tick(0, 0);
    chk(own(0) == 1 && own(2) == 1 && own(3) == 2 && own(5) == 2 && own(4) == 3 && own(6) == 3,
        "R7 start after downstream done", own(4), 3);
    tick(1, 0);
    chk(load_ready == 0, "R3 blocked", int'(load_ready), 0);
    tick(1, 0);
    chk(load_grp == 0, "R3 start ignored", int'(load_grp), 0);
    for (int i = 0; i < 4000; i++) begin
      logic [NU-1:0] d;
      for (int u = 0; u < NU; u++) d[u] = ($urandom % 4) == 0;
      tick(($urandom % 3) == 0, d);
    end
    finish_run();
  end
endmodule